// File: doc/BRIEF.md
# Manchester Bit Decision with Clock-Slot Ambiguity Resolver

This block sits behind a carrier-locked data arm and turns a stream of data-arm samples into decided bits. Each accepted sample enters a 13-deep delay line. When an external clock-recovery loop signals a phase wrap, the delay line is correlated against a split-phase bit shape. The shape is positive in its older half and negative in its newer half. The sign of the result is the candidate bit.

The recovered clock runs at twice the baud rate, so consecutive wraps alternate between two candidate slots. Only one slot lands on the true bit centre. The other slot straddles a bit boundary, where a split-phase waveform often has no transition, and there the correlation is weak. The block integrates the magnitude difference between the two slots, clamps the integral, and smooths it with a slow leaky average. The sign of the smoothed value picks the slot whose bit is released. A bit and a one-cycle valid pulse are produced once per bit period, on the second slot's wrap.

Top module: `manchester_slot_decider`

## Requirements
- R1: While `rstN` is low, and after it is released, `dataBit` and `bitValid` are 0, the delay line is empty, the slot pointer selects slot 0, and the integral and smoothed average are 0.
- R2: Every cycle with `sampleValid` high shifts `sampleIn` into the delay line. The correlation weights, listed from the oldest of the 13 most recent samples to the newest, are 1024, 4095, 4095, 0, 1024, 128, 0, -128, -1024, 0, -4095, -4095, -1024.
- R3: The correlation value is the weighted sum divided by 4096, rounded toward minus infinity. A wrap in a given cycle uses the samples accepted in earlier cycles.
- R4: The first wrap after reset is slot 0. Every later wrap uses the other slot from the previous wrap, and the slot does not change without a wrap.
- R5: `bitValid` goes high for exactly one cycle after each slot-1 wrap. If that wrap is sampled at clock edge k, the pulse appears after edge k+2. A slot-0 wrap produces no pulse.
- R6: On each slot-1 wrap the integral becomes integral + |corr of slot 1| − |corr of the latest slot-0 wrap|, limited to the range −4096 to +4096.
- R7: One cycle after that update, the average becomes avg − floor(avg/32) + floor(integral/32), using the new integral.
- R8: If the new average is negative, the released bit is the slot-0 bit of the current bit period. Otherwise it is the slot-1 bit.
- R9: A slot's bit is 1 when its correlation is strictly positive, and 0 when it is zero or negative.
- R10: `dataBit` changes only on the cycle in which `bitValid` is high, and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Accept `sampleIn` into the delay line this cycle |
| sampleIn | input | 16 | Signed data-arm sample |
| wrapStrobe | input | 1 | Recovered-clock phase wrap, one pulse per half bit |
| dataBit | output | 1 | Decided bit |
| bitValid | output | 1 | One-cycle pulse marking a new `dataBit` |

## Verification
The bench places single impulses at chosen delay-line positions, with amplitudes just above and below the /4096 boundary. A design that reversed the weight order, used the wrong shift, or rounded toward zero would then release the wrong bit. A second scenario feeds hundreds of bit periods in which slot 0 dominates, which drives the integral into its limit. It then reverses the dominance. The bench model predicts the exact bit period at which the released slot changes over, so a missing clamp, a wrong leak rate or an inverted selection moves that changeover and shows up as mismatched bits. Every slot-0 wrap is checked to produce no pulse and to leave `dataBit` unchanged. A design that emitted on both slots, or that did not alternate, fails those checks.

// File: rtl/msd_pkg.sv
package msd_pkg;

  // Strobes from control into the datapath
  typedef struct packed {
    logic capSlot0;  // latch slot-0 sign and magnitude
    logic capSlot1;  // slot-1 wrap: integral update, candidates latched
    logic updAvg;    // leaky average update
    logic emitBit;   // register decided bit and pulse valid
  } msdStrobes_t;

  // Correlation weight by sample age (0 = newest)
  function automatic int tapWeight(input int age);
    int w;
    case (age)
      0:  w = -1024;
      1:  w = -4095;
      2:  w = -4095;
      3:  w = 0;
      4:  w = -1024;
      5:  w = -128;
      6:  w = 0;
      7:  w = 128;
      8:  w = 1024;
      9:  w = 0;
      10: w = 4095;
      11: w = 4095;
      12: w = 1024;
      default: w = 0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/msd_correlator.sv
module msd_correlator #(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 13,
  parameter int TAPS     = 13,
  parameter int SHIFT    = 12,
  parameter int ACC_W    = SAMPLE_W + COEF_W + $clog2(TAPS),
  parameter int CORR_W   = ACC_W - SHIFT
) (
  input  logic signed [SAMPLE_W-1:0] tapsIn [TAPS],
  output logic signed [CORR_W-1:0]   corrOut
);
  import msd_pkg::*;

  logic signed [ACC_W-1:0] prod [TAPS];
  logic signed [ACC_W-1:0] acc;

  for (genvar g = 0; g < TAPS; g++) begin : gTap
    localparam logic signed [COEF_W-1:0] COEF = COEF_W'(tapWeight(g));
    logic signed [ACC_W-1:0] xExt;
    logic signed [ACC_W-1:0] cExt;
    assign xExt    = ACC_W'(tapsIn[g]);
    assign cExt    = ACC_W'(COEF);
    assign prod[g] = xExt * cExt;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) acc = acc + prod[i];
  end

  // Arithmetic shift: floor division by 2**SHIFT
  assign corrOut = CORR_W'(acc >>> SHIFT);

endmodule

// File: rtl/msd_ctrl.sv
module msd_ctrl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrapIn,
  output msd_pkg::msdStrobes_t strobes
);
  logic slot;
  logic updAvgQ;
  logic emitQ;
  logic capOne;

  assign capOne = wrapIn & slot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot    <= 1'b0;
      updAvgQ <= 1'b0;
      emitQ   <= 1'b0;
    end else begin
      if (wrapIn) slot <= ~slot;
      updAvgQ <= capOne;
      emitQ   <= updAvgQ;
    end
  end

  always_comb begin
    strobes.capSlot0 = wrapIn & ~slot;
    strobes.capSlot1 = capOne;
    strobes.updAvg   = updAvgQ;
    strobes.emitBit  = emitQ;
  end

  assert_slot_toggle_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrapIn |=> (slot != $past(slot)));

  assert_slot_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wrapIn |=> $stable(slot));

  assert_emit_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    emitQ |-> ($past(wrapIn, 2) && $past(slot, 2)));

endmodule

// File: rtl/msd_datapath.sv
module msd_datapath #(
  parameter int SAMPLE_W  = 16,
  parameter int COEF_W    = 13,
  parameter int TAPS      = 13,
  parameter int SHIFT     = 12,
  parameter int CLAMP     = 4096,
  parameter int AVG_SHIFT = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sampleValid,
  input  logic signed [SAMPLE_W-1:0]  sampleIn,
  input  msd_pkg::msdStrobes_t        strobes,
  output logic                        dataBit,
  output logic                        bitValid
);
  localparam int ACC_W  = SAMPLE_W + COEF_W + $clog2(TAPS);
  localparam int CORR_W = ACC_W - SHIFT;
  localparam int INT_W  = $clog2(CLAMP) + 2;
  localparam int SUM_W  = ((CORR_W > INT_W) ? CORR_W : INT_W) + 2;
  localparam int AVG_W  = INT_W + 2;

  logic signed [SAMPLE_W-1:0] taps [TAPS];
  logic signed [CORR_W-1:0]   corr;
  logic        [CORR_W-1:0]   corrMag;
  logic                       corrPos;

  logic        [CORR_W-1:0]   mag0;
  logic                       sign0;
  logic                       pendSign0;
  logic                       pendSign1;
  logic signed [INT_W-1:0]    integ;
  logic signed [INT_W-1:0]    integNext;
  logic signed [SUM_W-1:0]    rawSum;
  logic signed [AVG_W-1:0]    avg;
  logic signed [AVG_W-1:0]    avgNext;

  // Delay line, index 0 newest
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) taps[i] <= '0;
    end else if (sampleValid) begin
      taps[0] <= sampleIn;
      for (int i = 1; i < TAPS; i++) taps[i] <= taps[i-1];
    end
  end

  msd_correlator #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .TAPS     (TAPS),
    .SHIFT    (SHIFT),
    .ACC_W    (ACC_W),
    .CORR_W   (CORR_W)
  ) uCorr (
    .tapsIn  (taps),
    .corrOut (corr)
  );

  assign corrPos = (corr > 0);
  assign corrMag = corr[CORR_W-1] ? CORR_W'(-corr) : CORR_W'(corr);

  // Slot-difference integral with clamp
  always_comb begin
    rawSum = SUM_W'(integ)
           + SUM_W'(signed'({1'b0, corrMag}))
           - SUM_W'(signed'({1'b0, mag0}));
    if (rawSum > SUM_W'(CLAMP))
      integNext = INT_W'(CLAMP);
    else if (rawSum < -SUM_W'(CLAMP))
      integNext = -INT_W'(CLAMP);
    else
      integNext = INT_W'(rawSum);
  end

  // Leaky average
  assign avgNext = avg - (avg >>> AVG_SHIFT) + (AVG_W'(integ) >>> AVG_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mag0      <= '0;
      sign0     <= 1'b0;
      pendSign0 <= 1'b0;
      pendSign1 <= 1'b0;
      integ     <= '0;
      avg       <= '0;
      dataBit   <= 1'b0;
      bitValid  <= 1'b0;
    end else begin
      if (strobes.capSlot0) begin
        mag0  <= corrMag;
        sign0 <= corrPos;
      end
      if (strobes.capSlot1) begin
        integ     <= integNext;
        pendSign0 <= sign0;
        pendSign1 <= corrPos;
      end
      if (strobes.updAvg) avg <= avgNext;
      if (strobes.emitBit) dataBit <= avg[AVG_W-1] ? pendSign0 : pendSign1;
      bitValid <= strobes.emitBit;
    end
  end

  assert_integ_bounded_R6: assert property (@(posedge clk) disable iff (!rstN)
    (integ <= INT_W'(CLAMP)) && (integ >= -INT_W'(CLAMP)));

  assert_avg_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.updAvg |=> $stable(avg));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  assert_bit_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |-> $stable(dataBit));

endmodule

// File: rtl/manchester_slot_decider.sv
module manchester_slot_decider #(
  parameter int SAMPLE_W  = 16,
  parameter int COEF_W    = 13,
  parameter int TAPS      = 13,
  parameter int SHIFT     = 12,
  parameter int CLAMP     = 4096,
  parameter int AVG_SHIFT = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       wrapStrobe,
  output logic                       dataBit,
  output logic                       bitValid
);
  msd_pkg::msdStrobes_t strobes;

  msd_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrapIn  (wrapStrobe),
    .strobes (strobes)
  );

  msd_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .COEF_W    (COEF_W),
    .TAPS      (TAPS),
    .SHIFT     (SHIFT),
    .CLAMP     (CLAMP),
    .AVG_SHIFT (AVG_SHIFT)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleIn    (sampleIn),
    .strobes     (strobes),
    .dataBit     (dataBit),
    .bitValid    (bitValid)
  );

endmodule

// File: tb/manchester_slot_decider_test.sv
module manchester_slot_decider_test;
  localparam int CLK_PERIOD = 10;
  localparam int NTAP = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic wrapStrobe = 1'b0;
  logic dataBit;
  logic bitValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference weights, oldest first (R2)
  int refW [NTAP] = '{1024, 4095, 4095, 0, 1024, 128, 0, -128, -1024, 0, -4095, -4095, -1024};
  int patA [NTAP];
  int patB [NTAP];

  longint mIntegral = 0;
  longint mAvg = 0;
  longint mMag0 = 0;
  bit     mSign0 = 1'b0;

  manchester_slot_decider uut (
    .clk (clk), .rstN (rstN), .sampleValid (sampleValid), .sampleIn (sampleIn),
    .wrapStrobe (wrapStrobe), .dataBit (dataBit), .bitValid (bitValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint refCorr(input int p [NTAP]);
    longint s = 0;
    for (int i = 0; i < NTAP; i++) s += longint'(refW[i]) * longint'(p[i]);
    return s >>> 12;
  endfunction

  task automatic pushPat(input int p [NTAP]);
    for (int i = 0; i < NTAP; i++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleIn = 16'(p[i]);
    end
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // Wrap and observe: pulse expected only for slot 1 (R4, R5, R10)
  task automatic doWrap(input bit expectPulse, input bit expBit, input string req);
    bit held;
    @(negedge clk);
    held = dataBit;
    wrapStrobe = 1'b1;
    @(negedge clk);
    wrapStrobe = 1'b0;
    chk("R5 no early pulse", bitValid, 0);
    @(negedge clk);
    chk("R5 no early pulse", bitValid, 0);
    @(negedge clk);
    if (expectPulse) begin
      chk("R5 pulse after slot-1 wrap", bitValid, 1);
      chk(req, dataBit, expBit);
    end else begin
      chk("R4 slot-0 wrap gives no pulse", bitValid, 0);
      chk("R10 dataBit held", dataBit, held);
    end
    held = dataBit;
    @(negedge clk);
    chk("R5 single-cycle pulse", bitValid, 0);
    chk("R10 dataBit held", dataBit, held);
  endtask

  // One bit period: patA to slot 0, patB to slot 1, model per R6-R9
  task automatic runBit(input string req);
    longint c0, c1, m1, expB;
    pushPat(patA);
    c0 = refCorr(patA);
    mMag0 = (c0 < 0) ? -c0 : c0;
    mSign0 = (c0 > 0);
    doWrap(1'b0, 1'b0, req);
    pushPat(patB);
    c1 = refCorr(patB);
    m1 = (c1 < 0) ? -c1 : c1;
    mIntegral = mIntegral + m1 - mMag0;
    if (mIntegral > 4096) mIntegral = 4096;
    if (mIntegral < -4096) mIntegral = -4096;
    mAvg = mAvg - (mAvg >>> 5) + (mIntegral >>> 5);
    expB = (mAvg < 0) ? longint'(mSign0) : longint'(c1 > 0);
    doWrap(1'b1, expB[0], req);
  endtask

  function automatic void setShape(ref int p [NTAP], input int amp);
    for (int i = 0; i < NTAP; i++)
      p[i] = (refW[i] > 0) ? amp : ((refW[i] < 0) ? -amp : 0);
  endfunction

  function automatic void setImpulse(ref int p [NTAP], input int idx, input int amp);
    for (int i = 0; i < NTAP; i++) p[i] = (i == idx) ? amp : 0;
  endfunction

  task automatic testReset();
    chk("R1 dataBit in reset", dataBit, 0);
    chk("R1 bitValid in reset", bitValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 dataBit after reset", dataBit, 0);
    chk("R1 bitValid after reset", bitValid, 0);
  endtask

  // Impulses near the /4096 boundary, slot 0 silent so slot 1 wins (R2, R3, R9)
  task automatic testImpulses();
    setImpulse(patA, 0, 0);
    setImpulse(patB, 5, 33);  runBit("R2 weight 128 at push index 5");
    setImpulse(patB, 5, 31);  runBit("R3 floor 3968/4096 gives 0, R9 zero is 0");
    setImpulse(patB, 5, 32);  runBit("R3 exactly 4096 gives 1");
    setImpulse(patB, 7, 31);  runBit("R3 floor of negative, R9 negative is 0");
    setImpulse(patB, 0, 4);   runBit("R2 oldest weight 1024");
    setImpulse(patB, 12, -4); runBit("R2 newest weight -1024");
    setImpulse(patB, 3, 30000); runBit("R2 zero-weight tap");
  endtask

  task automatic testPolarity();
    setImpulse(patA, 0, 0);
    setShape(patB, 300);  runBit("R9 positive shape gives 1");
    setShape(patB, -300); runBit("R9 negative shape gives 0");
  endtask

  // Slot dominance reversal through the clamp (R6, R7, R8)
  task automatic testSelect();
    setShape(patA, 200);
    setShape(patB, -10);
    for (int k = 0; k < 250; k++) runBit("R8 slot 0 dominant, R6 clamp");
    chk("R6 model integral saturated", mIntegral, -4096);
    setShape(patA, -10);
    setShape(patB, 200);
    for (int k = 0; k < 250; k++) runBit("R7 recovery timing, R8 slot 1 dominant");
  endtask

  initial begin
    testReset();
    testImpulses();
    testPolarity();
    testSelect();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule